// File: doc/BRIEF.md
# Cache-Block Zero Store Engine

This block carries out a single "zero this cache block" operation on behalf of a processor pipeline. A request brings a virtual address, the current privilege level, a flag that says whether the hart runs virtualized, and three per-level enables (machine, hypervisor, supervisor) that grant lower levels permission to use the operation. The block first decides whether the request must trap. It can return an illegal-instruction code or a virtual-instruction code.

When the request may proceed, the address is rounded down to the block boundary. The engine then writes a zero byte to every location in the block, lowest address first, over a valid/ready byte-write port. It does this regardless of whether the target is cacheable memory or a device region. A store fault returned with any write acknowledge stops the sequence at once. Each request finishes with a one-cycle pulse: done for success, or fault with a code. A busy flag spans the whole store sequence, and no new request is taken while it is set.

Top module: `cbz_engine`

## Requirements
- R1: A request at a privilege below machine (privilege codes: user 0, supervisor 1, machine 3) with the machine enable clear ends, one cycle after acceptance, with a fault pulse carrying code 1 (illegal instruction). No write is issued.
- R2: If R1 does not apply, a virtualized request at supervisor or user level with the hypervisor enable clear ends with a fault pulse carrying code 2 (virtual instruction). No write is issued.
- R3: If R1 and R2 do not apply, a virtualized user-level request with the supervisor enable clear ends with code 2. No write is issued.
- R4: If none of R1 to R3 applies, a user-level request with the supervisor enable clear ends with code 1. No write is issued.
- R5: The machine-enable check takes priority over both virtual checks. A virtualized user request with every enable clear reports code 1.
- R6: The first write of a permitted request targets the request address with its low log2(BLK_BYTES) bits cleared.
- R7: A permitted request issues exactly BLK_BYTES writes, all with data 0x00, to consecutive ascending byte addresses. The address and valid are held while the port stalls.
- R8: busy rises on the cycle after a permitted request is accepted and stays high until the final acknowledge. req_ready is low while busy is set, and a request offered then has no effect.
- R9: After the last acknowledge without a fault, busy falls and rsp_done pulses for exactly one cycle with rsp_code 0. A done pulse and a fault pulse never occur together.
- R10: An acknowledge with wr_fault high ends the sequence. busy falls, rsp_fault pulses with code 3 (store fault), and no further write is issued, including when the fault comes on the final byte.
- R11: After reset, busy, wr_valid, rsp_done and rsp_fault are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_addr | input | AW | Target address, any alignment |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Hart runs virtualized |
| cfg_en_m | input | 1 | Machine-level enable |
| cfg_en_h | input | 1 | Hypervisor-level enable |
| cfg_en_s | input | 1 | Supervisor-level enable |
| busy | output | 1 | Store sequence in progress |
| wr_valid | output | 1 | Byte write offered |
| wr_ready | input | 1 | Byte write acknowledged this cycle |
| wr_addr | output | AW | Byte write address |
| wr_data | output | 8 | Byte write data (always zero) |
| wr_fault | input | 1 | Acknowledged write faulted |
| rsp_done | output | 1 | One-cycle success pulse |
| rsp_fault | output | 1 | One-cycle fault pulse |
| rsp_code | output | 2 | 0 ok, 1 illegal instruction, 2 virtual instruction, 3 store fault |

## Verification
Completion and the store fault can land on the same acknowledge edge when the memory faults on the final byte of the block. The bench provokes this by raising wr_fault together with wr_ready on the last write only. It then expects a single fault pulse with code 3, no done pulse, and busy low afterwards. The other collision is a fresh request arriving while the sequence runs. The bench holds req_valid high, with a different address, for the whole busy window. It then checks that the beat count and the address stream are those of the first request alone, and that a single completion pulse follows.

// File: rtl/cbz_pkg.sv
package cbz_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    RC_OK      = 2'd0,
    RC_ILLEGAL = 2'd1,
    RC_VIRTUAL = 2'd2,
    RC_STORE   = 2'd3
  } rcode_e;
endpackage

// File: rtl/cbz_perm_check.sv
module cbz_perm_check
  import cbz_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       en_m,
  input  logic       en_h,
  input  logic       en_s,
  output logic       deny,
  output logic [1:0] code
);
  logic below_m, upto_s, below_s;
  logic m_trip, v_trip, s_trip;

  assign below_m = (priv != PRIV_MACH);
  assign upto_s  = (priv <= PRIV_SUPV);
  assign below_s = (priv == PRIV_USER);

  assign m_trip = below_m && !en_m;
  assign v_trip = virt && ((upto_s && !en_h) || (below_s && !en_s));
  assign s_trip = below_s && !en_s;

  // Fixed order: machine enable, then virtual checks, then supervisor enable.
  always_comb begin
    deny = 1'b1;
    code = RC_ILLEGAL;
    if (m_trip) begin
      code = RC_ILLEGAL;
    end else if (v_trip) begin
      code = RC_VIRTUAL;
    end else if (s_trip) begin
      code = RC_ILLEGAL;
    end else begin
      deny = 1'b0;
      code = RC_OK;
    end
  end
endmodule

// File: rtl/cbz_store_seq.sv
module cbz_store_seq #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          wr_ready,
  input  logic          wr_fault,
  output logic          busy,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          last_ack,
  output logic          fault_ack
);
  localparam int OFFW = $clog2(BLK_BYTES);
  localparam logic [OFFW-1:0] LAST_IDX = OFFW'(BLK_BYTES - 1);

  logic            busy_q;
  logic [AW-1:0]   base_q;
  logic [OFFW-1:0] idx_q;
  logic            ack;

  assign ack       = busy_q && wr_ready;
  assign fault_ack = ack && wr_fault;
  assign last_ack  = ack && !wr_fault && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      base_q <= base;
      idx_q  <= '0;
    end else if (ack) begin
      if (wr_fault || idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign wr_valid = busy_q;
  assign wr_addr  = base_q | AW'(idx_q);
endmodule

// File: rtl/cbz_engine.sv
module cbz_engine
  import cbz_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_priv,
  input  logic          req_virt,
  input  logic          cfg_en_m,
  input  logic          cfg_en_h,
  input  logic          cfg_en_s,
  output logic          busy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_fault,
  output logic          rsp_done,
  output logic          rsp_fault,
  output logic [1:0]    rsp_code
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BLK_BYTES - 1);

  logic          accept, deny, start;
  logic [1:0]    deny_code;
  logic [AW-1:0] aligned;
  logic          last_ack, fault_ack;

  cbz_perm_check u_perm (
    .priv (req_priv),
    .virt (req_virt),
    .en_m (cfg_en_m),
    .en_h (cfg_en_h),
    .en_s (cfg_en_s),
    .deny (deny),
    .code (deny_code)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !deny;
  assign aligned   = req_addr & ALIGN_MASK;

  cbz_store_seq #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .base      (aligned),
    .wr_ready  (wr_ready),
    .wr_fault  (wr_fault),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .last_ack  (last_ack),
    .fault_ack (fault_ack)
  );

  assign wr_data = 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= RC_OK;
    end else begin
      rsp_done  <= last_ack;
      rsp_fault <= fault_ack || (accept && deny);
      if (fault_ack)          rsp_code <= RC_STORE;
      else if (accept && deny) rsp_code <= deny_code;
      else                    rsp_code <= RC_OK;
    end
  end
endmodule

// File: rtl/cbz_engine_chk.sv
module cbz_engine_chk #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_priv,
  input logic          req_virt,
  input logic          cfg_en_m,
  input logic          cfg_en_h,
  input logic          cfg_en_s,
  input logic          busy,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          wr_fault,
  input logic          rsp_done,
  input logic          rsp_fault,
  input logic [1:0]    rsp_code
);
  localparam int OFFW = $clog2(BLK_BYTES);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_mach_gate_R1: assert property (@(posedge clk) disable iff (rst)
    acc && req_priv != 2'd3 && !cfg_en_m |=> rsp_fault && rsp_code == 2'd1 && !wr_valid);

  assert_virt_hyp_R2: assert property (@(posedge clk) disable iff (rst)
    acc && cfg_en_m && req_virt && req_priv <= 2'd1 && !cfg_en_h
    |=> rsp_fault && rsp_code == 2'd2 && !wr_valid);

  assert_virt_sup_R3: assert property (@(posedge clk) disable iff (rst)
    acc && cfg_en_m && req_virt && req_priv == 2'd0 && !cfg_en_s
    |=> rsp_fault && rsp_code == 2'd2);

  assert_user_gate_R4: assert property (@(posedge clk) disable iff (rst)
    acc && cfg_en_m && !req_virt && req_priv == 2'd0 && !cfg_en_s
    |=> rsp_fault && rsp_code == 2'd1);

  assert_align_R6: assert property (@(posedge clk) disable iff (rst)
    acc && req_priv == 2'd3 && !req_virt |=> wr_valid && wr_addr[OFFW-1:0] == '0);

  assert_zero_data_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_data == 8'h00);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && !wr_fault && wr_addr[OFFW-1:0] != OFFW'(BLK_BYTES - 1)
    |=> wr_valid && wr_addr == $past(wr_addr) + 1'b1);

  assert_ready_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rsp_done && rsp_fault));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_fault_abort_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && wr_fault |=> !busy && !wr_valid && rsp_fault && rsp_code == 2'd3);
endmodule

bind cbz_engine cbz_engine_chk #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_priv(req_priv), .req_virt(req_virt), .cfg_en_m(cfg_en_m),
  .cfg_en_h(cfg_en_h), .cfg_en_s(cfg_en_s), .busy(busy), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_fault(wr_fault),
  .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_code(rsp_code)
);

// File: tb/test_cbz_engine.sv
module test_cbz_engine;
  localparam int AW  = 32;
  localparam int BLK = 64;
  localparam int NV  = 10;
  // {priv[1:0], virt, en_m, en_h, en_s, code[1:0]}
  localparam logic [7:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_priv = 2'd3;
  logic req_virt = 1'b0, cfg_en_m = 1'b0, cfg_en_h = 1'b0, cfg_en_s = 1'b0;
  logic busy, wr_valid, wr_ready = 1'b0, wr_fault = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic rsp_done, rsp_fault;
  logic [1:0] rsp_code;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cbz_engine #(.AW(AW), .BLK_BYTES(BLK)) i_cbz_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_priv(req_priv), .req_virt(req_virt),
    .cfg_en_m(cfg_en_m), .cfg_en_h(cfg_en_h), .cfg_en_s(cfg_en_s),
    .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_fault(wr_fault), .rsp_done(rsp_done),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one request; code: 0..3 from the pulse, 4 = done/fault mismatch, -1 = no pulse.
  task automatic run_req(input logic [AW-1:0] addr, input logic [1:0] pv, input logic vt,
                         input logic em, input logic eh, input logic es,
                         input logic stall, input int fault_at, input logic poke,
                         output int code, output int beats, output int bad_addr,
                         output int bad_data, output int ready_busy);
    logic [AW-1:0] base;
    int cyc;
    base = addr & ~AW'(BLK - 1);
    code = -1; beats = 0; bad_addr = 0; bad_data = 0; ready_busy = 0; cyc = 0;
    @(negedge clk);
    req_addr = addr; req_priv = pv; req_virt = vt;
    cfg_en_m = em; cfg_en_h = eh; cfg_en_s = es; req_valid = 1'b1;
    @(negedge clk);
    req_valid = poke;
    if (poke) begin
      req_addr = addr ^ 32'h0000_5000; req_priv = 2'd3;
    end
    while (cyc < 4000) begin
      cyc++;
      wr_ready = 1'b0; wr_fault = 1'b0;
      if (rsp_done || rsp_fault) begin
        code = (rsp_done && rsp_code == 2'd0) ? 0 : (rsp_fault ? int'(rsp_code) : 4);
        break;
      end
      if (busy && req_ready) ready_busy++;
      if (wr_valid && (!stall || cyc[0])) begin
        if (wr_addr != base + AW'(beats)) bad_addr++;
        if (wr_data != 8'h00) bad_data++;
        wr_ready = 1'b1;
        wr_fault = (beats == fault_at);
        beats++;
      end
      @(negedge clk);
    end
    req_valid = 1'b0; wr_ready = 1'b0; wr_fault = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int code, beats, ba, bd, rb;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !wr_valid && !rsp_done && !rsp_fault && req_ready, "R11 reset outputs",
          {busy, wr_valid, rsp_done, rsp_fault, req_ready}, 5'b00001);
    rst = 1'b0;

    // Vector table: permission decision and full block writes
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      int exp_code;
      a = 32'h1000_0000 + AW'(i) * 32'h0000_0111 + 32'h2B;
      exp_code = int'(VEC[i][1:0]);
      run_req(a, VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
              1'b0, -1, 1'b0, code, beats, ba, bd, rb);
      // R1 R2 R3 R4 R5: code by fixed check order
      check(code == exp_code, $sformatf("R1-R5 vector %0d code (R5)", i), code, exp_code);
      if (exp_code != 0) begin
        check(beats == 0, $sformatf("R1 vector %0d no writes on trap", i), beats, 0);
      end else begin
        check(beats == BLK && ba == 0, $sformatf("R6 R7 vector %0d beats/addr", i), beats, BLK);
        check(bd == 0, "R7 zero data", bd, 0);
        @(negedge clk);
        check(!rsp_done && !busy, "R9 done lasts one cycle", rsp_done, 0);
      end
    end

    // R7 stalled port, aligned address already
    run_req(32'h2000_0040, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1'b0, code, beats, ba, bd, rb);
    check(code == 0 && beats == BLK && ba == 0, "R7 stalled block", beats, BLK);

    // R8 request offered while busy is ignored
    run_req(32'h3000_00FF, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, -1, 1'b1, code, beats, ba, bd, rb);
    check(code == 0 && beats == BLK && ba == 0, "R8 poke during busy", beats, BLK);
    check(rb == 0, "R8 req_ready low while busy", rb, 0);
    @(negedge clk);
    check(!busy && !wr_valid && !rsp_done, "R8 no second sequence", {busy, wr_valid}, 0);

    // R10 fault mid-block
    run_req(32'h4000_0013, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10, 1'b0, code, beats, ba, bd, rb);
    check(code == 3, "R10 mid fault code", code, 3);
    check(beats == 11 && ba == 0, "R10 writes stop at fault", beats, 11);
    check(!busy && !wr_valid, "R10 busy dropped", {busy, wr_valid}, 0);

    // R10 fault on final byte collides with completion
    run_req(32'h5000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, BLK - 1, 1'b0, code, beats, ba, bd, rb);
    check(code == 3, "R10 last-byte fault wins over done (R9)", code, 3);
    check(beats == BLK, "R10 last-byte beats", beats, BLK);
    @(negedge clk);
    check(!rsp_done && !rsp_fault && !wr_valid, "R10 nothing after abort",
          {rsp_done, rsp_fault, wr_valid}, 0);

    // R11 reset mid-sequence
    @(negedge clk);
    req_addr = 32'h6000_0000; req_priv = 2'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R8 busy after accept", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !wr_valid && req_ready && !rsp_done && !rsp_fault, "R11 reset clears",
          {busy, wr_valid}, 0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule